// File: doc/BRIEF.md
# Proportional-Integral Saturating Control Word Integrator

This block sits between the scaled phase-error pulse sources and a counter-based oscillator in an all-digital clock loop. It runs on a fast counting clock and keeps two saturating up/down counters. The integral counter runs without a break across reference periods and accumulates the net of the integral-path up and down pulses. The proportional counter restarts from the integral value on every reference event and then adds the proportional-path pulses.

The reference signal is asynchronous to the counting clock. It passes through a synchronizer, and each rising edge of the reference gives a one-cycle strobe. On that strobe the proportional count is frozen into the registered control word, and the proportional counter is reseeded from the integral counter. Both counters clamp at full scale and at zero instead of wrapping. The control word is a level that holds between strobes. It has no valid/ready handshake because the oscillator reads it continuously and cannot push back. The pulse inputs are plain per-cycle levels, sampled on every counting-clock edge.

Top module: `pi_sat_integrator`

## Requirements
- R1: While reset is asserted (rst_n low), both counters and ctrl_word take the mid-scale value RESET_VAL, which is 128 for the default 8-bit width.
- R2: On each counting clock cycle the integral counter adds one when up_i alone is 1 and subtracts one when dn_i alone is 1.
- R3: Neither counter wraps. An increment at 2^CW_WIDTH-1 (255 by default) leaves the value unchanged, and so does a decrement at 0.
- R4: In a cycle where both the up and the down input of a counter are 1, that counter keeps its value.
- R5: ref_in passes through a two-flop synchronizer. A rising edge gives exactly one strobe. If the first counting clock edge that samples ref_in high is edge k, ctrl_word changes at edge k+2. A reference that stays high, or that falls, gives no strobe.
- R6: On a strobe, ctrl_word takes the proportional count as it stood before that cycle's reload. Between strobes, ctrl_word does not change, whatever the pulse inputs do.
- R7: On a strobe cycle the proportional counter loads the integral count including that same cycle's integral step, and the proportional pulses of that cycle are discarded.
- R8: Outside strobe cycles the proportional counter adds one on up_p alone and subtracts one on dn_p alone.
- R9: The integral counter is never reloaded by a strobe. Its value carries over from one reference period to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cnt | input | 1 | Fast counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference event signal, asynchronous to clk_cnt |
| up_p | input | 1 | Proportional-path up pulse |
| dn_p | input | 1 | Proportional-path down pulse |
| up_i | input | 1 | Integral-path up pulse |
| dn_i | input | 1 | Integral-path down pulse |
| ctrl_word | output | CW_WIDTH | Registered oscillator control word |

## Verification
The bound checker checks the following on every cycle:
- clamping at both ends of the integral counter;
- the hold when up and down are both asserted;
- single-cycle strobes;
- the unit step of the proportional counter;
- that the control word moves only after a strobe and then equals the prior proportional count.

Other behaviour shows only at the ports over several reference periods, so it is left to the bench's directed scenarios:
- that the proportional counter really reseeds from the integral value, including that cycle's integral step;
- that the integral value persists across periods;
- the exact two-edge synchronizer latency;
- that no strobe comes from a reference held high.

// File: rtl/pi_int_pkg.sv
package pi_int_pkg;

  typedef enum logic [1:0] {
    STEP_HOLD = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2
  } step_e;

  // Conflicting or absent pulses both resolve to a hold.
  function automatic step_e decode_step(input logic up, input logic dn);
    if (up && !dn)      return STEP_UP;
    else if (dn && !up) return STEP_DOWN;
    else                return STEP_HOLD;
  endfunction

endpackage

// File: rtl/ref_edge_sync.sv
module ref_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_async,
  output logic strobe
);
  localparam int LAST = STAGES;

  // sh[0..STAGES-1] are the synchronizer flops, sh[STAGES] is the edge-detect history
  logic [LAST:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[LAST-1:0], ref_async};
  end

  assign strobe = sh[LAST-1] & ~sh[LAST];
endmodule

// File: rtl/sat_counter.sv
module sat_counter
  import pi_int_pkg::*;
#(
  parameter int                 WIDTH     = 8,
  parameter logic [WIDTH-1:0]   RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up,
  input  logic             dn,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] count_next
);
  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] BOTTOM = '0;

  always_comb begin
    count_next = count;
    unique case (decode_step(up, dn))
      STEP_UP:   if (count != TOP)    count_next = count + 1'b1;
      STEP_DOWN: if (count != BOTTOM) count_next = count - 1'b1;
      default:   count_next = count;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= RESET_VAL;
    else if (load) count <= load_val;
    else           count <= count_next;
  end
endmodule

// File: rtl/pi_sat_integrator.sv
module pi_sat_integrator #(
  parameter int                    CW_WIDTH    = 8,
  parameter int                    SYNC_STAGES = 2,
  parameter logic [CW_WIDTH-1:0]   RESET_VAL   = {1'b1, {(CW_WIDTH-1){1'b0}}}
) (
  input  logic                clk_cnt,
  input  logic                rst_n,
  input  logic                ref_in,
  input  logic                up_p,
  input  logic                dn_p,
  input  logic                up_i,
  input  logic                dn_i,
  output logic [CW_WIDTH-1:0] ctrl_word
);
  logic                strobe;
  logic [CW_WIDTH-1:0] i_cnt, i_next;
  logic [CW_WIDTH-1:0] p_cnt, p_next;

  ref_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_cnt),
    .rst_n    (rst_n),
    .ref_async(ref_in),
    .strobe   (strobe)
  );

  // Integral path: never reloaded, carries across reference periods
  sat_counter #(.WIDTH(CW_WIDTH), .RESET_VAL(RESET_VAL)) u_integ (
    .clk       (clk_cnt),
    .rst_n     (rst_n),
    .up        (up_i),
    .dn        (dn_i),
    .load      (1'b0),
    .load_val  (RESET_VAL),
    .count     (i_cnt),
    .count_next(i_next)
  );

  // Proportional path: reseeded from the integral's updated value on each strobe
  sat_counter #(.WIDTH(CW_WIDTH), .RESET_VAL(RESET_VAL)) u_prop (
    .clk       (clk_cnt),
    .rst_n     (rst_n),
    .up        (up_p),
    .dn        (dn_p),
    .load      (strobe),
    .load_val  (i_next),
    .count     (p_cnt),
    .count_next(p_next)
  );

  always_ff @(posedge clk_cnt or negedge rst_n) begin
    if (!rst_n)      ctrl_word <= RESET_VAL;
    else if (strobe) ctrl_word <= p_cnt;
  end
endmodule

// File: rtl/pi_sat_integrator_chk.sv
module pi_sat_integrator_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         strobe,
  input logic         up_p,
  input logic         dn_p,
  input logic         up_i,
  input logic         dn_i,
  input logic [W-1:0] i_cnt,
  input logic [W-1:0] p_cnt,
  input logic [W-1:0] ctrl_word
);
  localparam logic [W-1:0] FULL = '1;
  localparam logic [W-1:0] ZERO = '0;

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (i_cnt == FULL && up_i && !dn_i) |=> (i_cnt == FULL));

  p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (i_cnt == ZERO && dn_i && !up_i) |=> (i_cnt == ZERO));

  p_conflict_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (up_i && dn_i) |=> $stable(i_cnt));

  p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);

  p_word_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> (ctrl_word == $past(p_cnt)));

  p_word_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(ctrl_word));

  p_prop_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe && up_p && !dn_p && p_cnt != FULL) |=> (p_cnt == $past(p_cnt) + 1'b1));
endmodule

bind pi_sat_integrator pi_sat_integrator_chk #(.W(CW_WIDTH)) u_chk (
  .clk      (clk_cnt),
  .rst_n    (rst_n),
  .strobe   (strobe),
  .up_p     (up_p),
  .dn_p     (dn_p),
  .up_i     (up_i),
  .dn_i     (dn_i),
  .i_cnt    (i_cnt),
  .p_cnt    (p_cnt),
  .ctrl_word(ctrl_word)
);

// File: tb/pi_sat_integrator_test.sv
`timescale 1ns/1ps
module pi_sat_integrator_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ref_in = 1'b0;
  logic         up_p = 1'b0, dn_p = 1'b0, up_i = 1'b0, dn_i = 1'b0;
  logic [W-1:0] ctrl_word;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #4 clk = ~clk;

  pi_sat_integrator #(.CW_WIDTH(W)) uut (
    .clk_cnt(clk), .rst_n(rst_n), .ref_in(ref_in),
    .up_p(up_p), .dn_p(dn_p), .up_i(up_i), .dn_i(dn_i),
    .ctrl_word(ctrl_word)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: ctrl_word actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One counting-clock cycle: drive at the falling edge, return at the next falling edge
  task automatic cyc(input logic r, input logic upp, input logic dnp,
                     input logic upi, input logic dni);
    ref_in = r; up_p = upp; dn_p = dnp; up_i = upi; dn_i = dni;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  // Reference pulse; the strobe lands on the third call's edge
  task automatic fire_ref();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    idle(3);
  endtask

  task automatic t_reset();
    check("R1", ctrl_word, 128);
  endtask

  task automatic t_integral();
    for (int k = 0; k < 10; k++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    fire_ref();
    check("R6", ctrl_word, 128);   // prior proportional value
    fire_ref();
    check("R2", ctrl_word, 138);   // 128 + 10
    for (int k = 0; k < 4; k++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    fire_ref();
    fire_ref();
    check("R9", ctrl_word, 134);   // integral kept 138 then dropped 4
  endtask

  task automatic t_prop();
    for (int k = 0; k < 5; k++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6", ctrl_word, 134);   // pulses without strobe do not reach the word
    fire_ref();
    check("R8", ctrl_word, 139);
  endtask

  task automatic t_hold();
    for (int k = 0; k < 6; k++) cyc(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    fire_ref();
    check("R4", ctrl_word, 134);   // proportional held at 134
    fire_ref();
    check("R4", ctrl_word, 134);   // integral held at 134
  endtask

  task automatic t_sat_high();
    for (int k = 0; k < 300; k++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    fire_ref();
    fire_ref();
    check("R3", ctrl_word, 255);
    for (int k = 0; k < 20; k++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    fire_ref();
    check("R3", ctrl_word, 255);
  endtask

  task automatic t_sat_low();
    for (int k = 0; k < 300; k++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    fire_ref();
    fire_ref();
    check("R3", ctrl_word, 0);
    for (int k = 0; k < 10; k++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    fire_ref();
    check("R3", ctrl_word, 0);
  endtask

  task automatic t_reload();
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);   // strobe cycle: integral step counts, upP discarded
    idle(1);
    fire_ref();
    check("R7", ctrl_word, 1);
  endtask

  task automatic t_timing();
    for (int k = 0; k < 3; k++) cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);   // proportional 4
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);   // edge k samples ref high
    check("R5", ctrl_word, 1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);   // edge k+1
    check("R5", ctrl_word, 1);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);   // edge k+2: word updates
    check("R5", ctrl_word, 4);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R5", ctrl_word, 4);           // steady high gives no strobe
    idle(2);
    fire_ref();
    check("R8", ctrl_word, 3);           // reseeded 1, plus 2
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_integral();
    t_prop();
    t_hold();
    t_sat_high();
    t_sat_low();
    t_reload();
    t_timing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule